// File: doc/BRIEF.md
# Page-Boundary Split Copy Sequencer

This block turns one virtual-address copy command into a series of page-bounded pieces. A command gives a start virtual address, a byte count and a direction. The sequencer cuts the range into chunks so that no chunk runs past the end of a page of `2**PAGE_BITS` bytes. Each chunk is sized from the current address and the bytes still left.

For every chunk it asks an external translator for the physical address of the chunk's first byte, and waits for the answer. Only then does it hand one physical transfer to the memory side. Each transfer carries the physical address, the length and the byte offset of the chunk within the caller's data buffer.

When a translation fails, the command is not aborted. On a write, that chunk is dropped. On a read, the chunk is still sent, but marked so that the buffer side fills it with zeros. In both cases a sticky error flag is raised and the walk goes on to the next chunk. A single-cycle done pulse closes every command, including a command with a byte count of zero.

Top module: `page_split_seq`

## Requirements
- R1: Each chunk length equals min(remaining bytes, 2**PAGE_BITS minus the low PAGE_BITS bits of the current virtual address). A chunk therefore never crosses a page boundary and is never zero.
- R2: When a command is accepted, the buffer offset starts at 0. After each chunk, the remaining count falls by the chunk length, and the virtual address and the buffer offset both rise by the chunk length.
- R3: Each chunk issues its own translation request, with `xlat_req_va` equal to the chunk's current virtual address. The request is held until `xlat_req_ready`. Only one translation is in flight at a time. A successful response (`xlat_rsp_ok`=1) leads to exactly one transfer whose `mem_req_pa` is the returned address.
- R4: Chunks continue while the remaining count is above zero. `done` is high in the cycle after the handshake that finishes the last chunk.
- R5: On a failed translation (`xlat_rsp_ok`=0) during a write command (`cmd_write`=1), that chunk gets no transfer, `err` is set, and the walk moves on to the next chunk.
- R6: On a failed translation during a read command (`cmd_write`=0), `err` is set. A transfer is still issued for that chunk with `mem_req_zero`=1, the chunk's length and the chunk's offset, and then the walk advances.
- R7: A command with `cmd_len`=0 raises `done` in the cycle after acceptance and makes no translation request and no transfer.
- R8: `err` is cleared when a command is accepted and stays set until the next acceptance. `done` is high for exactly one cycle per command. `cmd_ready` is high only while the block is idle.
- R9: While `rst_n` is low, and right after it is released: `cmd_ready`=1, `done`=0, `err`=0, `xlat_req_valid`=0 and `mem_req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when both are high |
| cmd_write | input | 1 | 1 = write to memory, 0 = read |
| cmd_va | input | VA_W | Start virtual address |
| cmd_len | input | LEN_W | Byte count |
| xlat_req_valid | output | 1 | Translation request pending |
| xlat_req_ready | input | 1 | Translator takes the request |
| xlat_req_va | output | VA_W | Virtual address to translate |
| xlat_rsp_valid | input | 1 | Translation answer present |
| xlat_rsp_ok | input | 1 | 1 = translation succeeded |
| xlat_rsp_pa | input | PA_W | Physical address of the requested byte |
| mem_req_valid | output | 1 | Physical transfer pending |
| mem_req_ready | input | 1 | Memory side takes the transfer |
| mem_req_write | output | 1 | Direction of the transfer |
| mem_req_zero | output | 1 | 1 = zero-fill this buffer span, no memory access |
| mem_req_pa | output | PA_W | Physical start address (0 when zero-filling) |
| mem_req_len | output | LEN_W | Chunk length in bytes |
| mem_req_ofs | output | LEN_W | Chunk offset within the data buffer |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky translation-failure flag |

## Verification
The bench builds the block with VA_W=8, PA_W=10, LEN_W=7 and PAGE_BITS=4, which gives 16-byte pages. With pages that small, a sweep over every start address in the first two pages and every length from 0 to 40 covers every chunk count from zero to four. It also covers chunks that end exactly on a boundary and first chunks of a single byte. Both directions are swept. The bench translator fails every address in page 2, so failures land on the first, middle and last chunks of different commands. Handshake stalls on both request ports follow a fixed cycle pattern, so each chunk sees different waits.

// File: rtl/page_split_pkg.sv
package page_split_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_XREQ   = 3'd1,
    ST_XWAIT  = 3'd2,
    ST_MREQ   = 3'd3,
    ST_FINISH = 3'd4
  } seq_state_t;
endpackage

// File: rtl/split_chunk_calc.sv
module split_chunk_calc #(
  parameter int LEN_W     = 7,
  parameter int PAGE_BITS = 4
) (
  input  logic [PAGE_BITS-1:0] va_low,
  input  logic [LEN_W-1:0]     rem,
  output logic [LEN_W-1:0]     chunk
);
  generate
    if (LEN_W > PAGE_BITS) begin : g_wide
      localparam logic [LEN_W-1:0] PAGE_SZ = LEN_W'(1) << PAGE_BITS;
      logic [LEN_W-1:0] room;
      always_comb begin
        room  = PAGE_SZ - {{(LEN_W-PAGE_BITS){1'b0}}, va_low};
        chunk = (rem < room) ? rem : room;
      end
    end else begin : g_narrow
      localparam int RW = PAGE_BITS + 1;
      localparam logic [RW-1:0] PAGE_SZ = RW'(1) << PAGE_BITS;
      logic [RW-1:0] room;
      logic [RW-1:0] rem_x;
      always_comb begin
        room  = PAGE_SZ - {1'b0, va_low};
        rem_x = RW'(rem);
        chunk = (rem_x < room) ? rem : LEN_W'(room);
      end
    end
  endgenerate
endmodule

// File: rtl/split_cursor.sv
module split_cursor #(
  parameter int VA_W  = 8,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VA_W-1:0]  load_va,
  input  logic [LEN_W-1:0] load_len,
  input  logic             step,
  input  logic [LEN_W-1:0] step_len,
  output logic [VA_W-1:0]  va_q,
  output logic [LEN_W-1:0] rem_q,
  output logic [LEN_W-1:0] ofs_q
);
  logic [VA_W-1:0]  va_d;
  logic [LEN_W-1:0] rem_d;
  logic [LEN_W-1:0] ofs_d;
  logic             en;

  always_comb begin
    en    = load | step;
    va_d  = va_q;
    rem_d = rem_q;
    ofs_d = ofs_q;
    if (load) begin
      va_d  = load_va;
      rem_d = load_len;
      ofs_d = '0;
    end else if (step) begin
      va_d  = va_q + VA_W'(step_len);
      rem_d = rem_q - step_len;
      ofs_d = ofs_q + step_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q  <= '0;
      rem_q <= '0;
      ofs_q <= '0;
    end else if (en) begin
      va_q  <= va_d;
      rem_q <= rem_d;
      ofs_q <= ofs_d;
    end
  end

  // R2: bytes done plus bytes left stay fixed between command loads
  p_sum_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (LEN_W'(rem_q + ofs_q) == $past(LEN_W'(rem_q + ofs_q))));

  // R2: a step never asks for more than what is left
  p_step_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (step_len <= rem_q));
endmodule

// File: rtl/page_split_seq.sv
module page_split_seq
  import page_split_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 40,
  parameter int LEN_W     = 16,
  parameter int PAGE_BITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_write,
  input  logic [VA_W-1:0]  cmd_va,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             xlat_req_valid,
  input  logic             xlat_req_ready,
  output logic [VA_W-1:0]  xlat_req_va,
  input  logic             xlat_rsp_valid,
  input  logic             xlat_rsp_ok,
  input  logic [PA_W-1:0]  xlat_rsp_pa,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic             mem_req_zero,
  output logic [PA_W-1:0]  mem_req_pa,
  output logic [LEN_W-1:0] mem_req_len,
  output logic [LEN_W-1:0] mem_req_ofs,
  output logic             done,
  output logic             err
);
  localparam int PAGE_SZ = 1 << PAGE_BITS;

  seq_state_t       state_q, state_d;
  logic             write_q, write_d;
  logic             zero_q, zero_d;
  logic [PA_W-1:0]  pa_q, pa_d;
  logic             err_q, err_d;
  logic             load, step, last, cmd_fire, cap_en;
  logic [VA_W-1:0]  cur_va;
  logic [LEN_W-1:0] cur_rem, cur_ofs, chunk;

  split_cursor #(.VA_W(VA_W), .LEN_W(LEN_W)) u_cursor (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_va  (cmd_va),
    .load_len (cmd_len),
    .step     (step),
    .step_len (chunk),
    .va_q     (cur_va),
    .rem_q    (cur_rem),
    .ofs_q    (cur_ofs)
  );

  split_chunk_calc #(.LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS)) u_chunk (
    .va_low (cur_va[PAGE_BITS-1:0]),
    .rem    (cur_rem),
    .chunk  (chunk)
  );

  assign cmd_fire = cmd_valid & cmd_ready;
  assign last     = (chunk == cur_rem);

  always_comb begin
    state_d = state_q;
    write_d = write_q;
    zero_d  = zero_q;
    pa_d    = pa_q;
    err_d   = err_q;
    load    = 1'b0;
    step    = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_fire) begin
          load    = 1'b1;
          write_d = cmd_write;
          err_d   = 1'b0;
          state_d = (cmd_len == '0) ? ST_FINISH : ST_XREQ;
        end
      end
      ST_XREQ: begin
        if (xlat_req_ready) state_d = ST_XWAIT;
      end
      ST_XWAIT: begin
        if (xlat_rsp_valid) begin
          cap_en = 1'b1;
          if (xlat_rsp_ok) begin
            pa_d    = xlat_rsp_pa;
            zero_d  = 1'b0;
            state_d = ST_MREQ;
          end else begin
            err_d  = 1'b1;
            pa_d   = '0;
            zero_d = 1'b1;
            if (write_q) begin
              step    = 1'b1;
              state_d = last ? ST_FINISH : ST_XREQ;
            end else begin
              state_d = ST_MREQ;
            end
          end
        end
      end
      ST_MREQ: begin
        if (mem_req_ready) begin
          step    = 1'b1;
          state_d = last ? ST_FINISH : ST_XREQ;
        end
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      zero_q  <= 1'b0;
      pa_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (load) write_q <= write_d;
      if (cap_en) begin
        zero_q <= zero_d;
        pa_q   <= pa_d;
      end
    end
  end

  assign cmd_ready      = (state_q == ST_IDLE);
  assign xlat_req_valid = (state_q == ST_XREQ);
  assign xlat_req_va    = cur_va;
  assign mem_req_valid  = (state_q == ST_MREQ);
  assign mem_req_write  = write_q;
  assign mem_req_zero   = zero_q;
  assign mem_req_pa     = pa_q;
  assign mem_req_len    = chunk;
  assign mem_req_ofs    = cur_ofs;
  assign done           = (state_q == ST_FINISH);
  assign err            = err_q;

  // R1: every transfer is non-empty and stays inside one page
  p_in_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ((mem_req_len != '0) &&
      (int'(cur_va[PAGE_BITS-1:0]) + int'(mem_req_len) <= PAGE_SZ)));

  // R3: translation and transfer are never requested together
  p_one_at_a_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && xlat_req_valid));

  // R3: a waiting translation request holds its address
  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_req_valid && !xlat_req_ready) |=> (xlat_req_valid && $stable(xlat_req_va)));

  // R5: a failed write chunk produces no transfer
  p_skip_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_XWAIT) && xlat_rsp_valid && !xlat_rsp_ok && write_q) |=> !mem_req_valid);

  // R6: a failed read chunk is zero-filled
  p_zero_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_XWAIT) && xlat_rsp_valid && !xlat_rsp_ok && !write_q) |=>
      (mem_req_valid && mem_req_zero));

  // R7: an empty command finishes on the next cycle
  p_empty_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && (cmd_len == '0)) |=> done);

  // R8: done is a single-cycle pulse, err clears on acceptance
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !err);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !cmd_fire) |=> err);
endmodule

// File: tb/test_page_split_seq.sv
module test_page_split_seq;
  localparam int VA_W = 8, PA_W = 10, LEN_W = 7, PAGE_BITS = 4;
  localparam int PSZ = 1 << PAGE_BITS;

  logic             clk, rst_n;
  logic             cmd_valid, cmd_ready, cmd_write;
  logic [VA_W-1:0]  cmd_va;
  logic [LEN_W-1:0] cmd_len;
  logic             xlat_req_valid, xlat_req_ready;
  logic [VA_W-1:0]  xlat_req_va;
  logic             xlat_rsp_valid, xlat_rsp_ok;
  logic [PA_W-1:0]  xlat_rsp_pa;
  logic             mem_req_valid, mem_req_ready, mem_req_write, mem_req_zero;
  logic [PA_W-1:0]  mem_req_pa;
  logic [LEN_W-1:0] mem_req_len, mem_req_ofs;
  logic             done, err;

  int checks = 0, failures = 0, cyc = 0;

  page_split_seq #(.VA_W(VA_W), .PA_W(PA_W), .LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS)) i_page_split_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_va(cmd_va), .cmd_len(cmd_len),
    .xlat_req_valid(xlat_req_valid), .xlat_req_ready(xlat_req_ready),
    .xlat_req_va(xlat_req_va),
    .xlat_rsp_valid(xlat_rsp_valid), .xlat_rsp_ok(xlat_rsp_ok), .xlat_rsp_pa(xlat_rsp_pa),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_zero(mem_req_zero),
    .mem_req_pa(mem_req_pa), .mem_req_len(mem_req_len), .mem_req_ofs(mem_req_ofs),
    .done(done), .err(err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit xl_fail(input int va);
    return ((va / PSZ) % 3) == 2;
  endfunction

  function automatic int xl_pa(input int va);
    return (va + 'h130) % (1 << PA_W);
  endfunction

  function automatic int exp_chunk(input int va, input int rem);
    int room;
    room = PSZ - (va % PSZ);
    return (rem < room) ? rem : room;
  endfunction

  task automatic run_cmd(input bit wr, input int va, input int len);
    int e_va, e_rem, e_ofs, guard, n_mem, n_mem_exp, ec;
    bit e_err, rsp_due, cur_fail, fin, want_done;
    e_va = va; e_rem = len; e_ofs = 0; e_err = 0;
    rsp_due = 0; cur_fail = 0; fin = 0; want_done = 0;
    guard = 0; n_mem = 0; n_mem_exp = 0;
    check(cmd_ready == 1'b1, "R8 ready when idle", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_write = wr; cmd_va = VA_W'(va); cmd_len = LEN_W'(len);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(err == 1'b0, "R8 err cleared at accept", err, 0);
    check(cmd_ready == 1'b0, "R8 busy after accept", cmd_ready, 0);
    if (len == 0) begin
      check(done == 1'b1, "R7 empty command done", done, 1);
      check(xlat_req_valid == 1'b0, "R7 no translation", xlat_req_valid, 0);
    end
    while (!fin) begin
      xlat_req_ready = 1'b0; xlat_rsp_valid = 1'b0; mem_req_ready = 1'b0;
      if (want_done) begin
        check(done == 1'b1, "R4 done after last chunk", done, 1);
        want_done = 0;
      end
      if (done) begin
        fin = 1;
      end else begin
        if (rsp_due) begin
          rsp_due = 0;
          xlat_rsp_valid = 1'b1;
          xlat_rsp_ok = !cur_fail;
          xlat_rsp_pa = PA_W'(xl_pa(e_va));
          if (cur_fail) e_err = 1;
          if (cur_fail && wr) begin
            ec = exp_chunk(e_va, e_rem);
            e_va += ec; e_rem -= ec; e_ofs += ec;
            if (e_rem == 0) want_done = 1;
          end else begin
            n_mem_exp++;
          end
        end else if (xlat_req_valid) begin
          check(int'(xlat_req_va) == e_va, "R3 translation address", xlat_req_va, e_va);
          check(e_rem > 0, "R4 request only with bytes left", e_rem, 1);
          if (cyc % 3 != 1) begin
            xlat_req_ready = 1'b1;
            rsp_due = 1;
            cur_fail = xl_fail(e_va);
          end
        end
        if (mem_req_valid) begin
          ec = exp_chunk(e_va, e_rem);
          check(int'(mem_req_len) == ec, "R1 chunk length", mem_req_len, ec);
          check(int'(mem_req_ofs) == e_ofs, "R2 buffer offset", mem_req_ofs, e_ofs);
          check(mem_req_write == wr, "R3 transfer direction", mem_req_write, wr);
          if (cur_fail) begin
            check(mem_req_zero == 1'b1, "R6 zero-fill on failed read", mem_req_zero, 1);
            check(!wr, "R5 no transfer on failed write", 1, 0);
          end else begin
            check(mem_req_zero == 1'b0, "R3 real transfer", mem_req_zero, 0);
            check(int'(mem_req_pa) == xl_pa(e_va), "R3 physical address", mem_req_pa, xl_pa(e_va));
          end
          if (cyc % 4 != 2) begin
            mem_req_ready = 1'b1;
            n_mem++;
            e_va += ec; e_rem -= ec; e_ofs += ec;
            if (e_rem == 0) want_done = 1;
          end
        end
        guard++;
        if (guard > 300) begin
          check(0, "R4 watchdog per command", guard, 300);
          fin = 1;
        end
        @(negedge clk);
      end
    end
    check(e_rem == 0, "R4 all bytes covered at done", e_rem, 0);
    check(n_mem == n_mem_exp, wr ? "R5 transfer count" : "R6 transfer count", n_mem, n_mem_exp);
    check(err == e_err, wr ? "R5 error flag" : "R6 error flag", err, e_err);
    @(negedge clk);
    check(done == 1'b0, "R8 done single cycle", done, 0);
    check(err == e_err, "R8 error sticky after done", err, e_err);
  endtask

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_va = '0; cmd_len = '0;
    xlat_req_ready = 1'b0; xlat_rsp_valid = 1'b0; xlat_rsp_ok = 1'b0; xlat_rsp_pa = '0;
    mem_req_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(cmd_ready == 1'b1 && done == 1'b0 && err == 1'b0, "R9 reset outputs",
          {cmd_ready, done, err}, 4);
    check(xlat_req_valid == 1'b0 && mem_req_valid == 1'b0, "R9 no requests in reset",
          {xlat_req_valid, mem_req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1 && done == 1'b0 && err == 1'b0, "R9 after release",
          {cmd_ready, done, err}, 4);
    for (int d = 0; d < 2; d++)
      for (int a = 0; a < 2 * PSZ; a++)
        for (int l = 0; l <= 40; l++)
          run_cmd(d[0], a, l);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #760000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule